// File: doc/BRIEF.md
# Fuse Array Shadow Loader

This block reads a one-time-programmable fuse array after reset and copies its contents into an on-chip shadow buffer. It does not wait for software to toggle the fuse control pins. It first enters read mode and waits a programmable settling time. It then strobes each word address in turn and captures the 32-bit data the array presents. When the last word is stored, it parks the array in a low-power standby encoding.

Other logic reads the shadow buffer through a one-cycle read port. Two fixed fields are decoded continuously: a 4-bit chip version and a 32-bit CPU leakage word. Until a load has completed, the read port and both decoded outputs return zero, so they never expose partial contents. A start pulse reruns the whole load from read-mode entry at any time.

Top module: `efuse_shadow_loader`

## Requirements
- R1: After reset is released, and on the cycle after a start pulse is sampled, the control word is 0x00C for SETTLE_CYC cycles. In that word, load (bit 2) and program-enable-bar (bit 3) are high, chip-select-bar (bit 0) is low, strobe (bit 1) is low and the address field is zero.
- R2: Words are read at addresses 0, 1, ... in increasing order, with the address in bits 15:6 of the control word. Each word takes three phases of SETTLE_CYC cycles each: strobe low, strobe high, strobe low. Load and program-enable-bar stay high and chip-select-bar stays low throughout.
- R3: The value stored for a word is the array data output in the last cycle in which strobe is high for that address.
- R4: Exactly WORDS (32) words are read. The address field never holds a value of WORDS or more, so address 32 is never strobed.
- R5: Once the last word has been read, the control word becomes 0x009 (program-enable-bar and chip-select-bar high, all else zero). The done output is high exactly while that standby encoding is driven.
- R6: While done is low, chip_ver and cpu_leak are zero. A read issued while done is low returns zero.
- R7: rd_data, one clock after rd_idx is presented with done high, equals shadow word rd_idx.
- R8: chip_ver equals bits 3:0 of shadow word 6, and cpu_leak equals all of shadow word 23.
- R9: A start pulse at any point clears done on the next cycle and restarts from read-mode entry. The buffer is reloaded from the array's current contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the load sequence |
| fuse_ctrl | output | 16 | Fuse control word: bit0 chip-select-bar, bit1 strobe, bit2 load, bit3 program-enable-bar, bits 15:6 address |
| fuse_dout | input | 32 | Data output of the fuse array |
| rd_idx | input | 5 | Shadow word index for the read port |
| rd_data | output | 32 | Shadow word read, valid one cycle after rd_idx |
| done | output | 1 | Load complete, array in standby |
| chip_ver | output | 4 | Decoded chip version field |
| cpu_leak | output | 32 | Decoded CPU leakage word |

## Verification
The embedded properties check the following on every cycle: the settle counter stays in range, the address field stays below the word count, and strobe only appears in read mode. They also check that captures only happen with strobe high, that done always coincides with the standby word, and that a start clears done. The zero gating of the read port and of the decoded fields is checked the same way.

Only the bench scenarios can show the rest. These are the exact phase lengths and the address order across a whole load, and the fact that the captured data matches each fuse word. They also cover field decoding of specific patterns and a restart partway through a load that leaves only the new contents in the buffer.

// File: rtl/efuse_shadow_pkg.sv
`timescale 1ns/1ps
package efuse_shadow_pkg;
   // control word bit positions (decoded by the fuse macro)
   localparam int CSB_BIT    = 0;
   localparam int STROBE_BIT = 1;
   localparam int LOAD_BIT   = 2;
   localparam int PGENB_BIT  = 3;
   localparam int ADDR_LSB   = 6;

   typedef enum logic [2:0] {
      PH_ENTER = 3'd0,
      PH_ADDR  = 3'd1,
      PH_STRB  = 3'd2,
      PH_LOW   = 3'd3,
      PH_STBY  = 3'd4
   } seq_ph_e;
endpackage

// File: rtl/efuse_settle_timer.sv
`timescale 1ns/1ps
module efuse_settle_timer #(
   parameter int SETTLE_CYC = 200,
   localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(SETTLE_CYC - 1);
      else if (reload)
         cnt <= CNT_W'(SETTLE_CYC - 1);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) < SETTLE_CYC);
endmodule

// File: rtl/efuse_load_fsm.sv
`timescale 1ns/1ps
module efuse_load_fsm import efuse_shadow_pkg::*; #(
   parameter int WORDS  = 32,
   parameter int ADDR_W = 10,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int CTRL_W = ADDR_LSB + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              expired,
   output logic              reload,
   output logic              cap_en,
   output logic [IDX_W-1:0]  cap_idx,
   output logic [CTRL_W-1:0] ctrl,
   output logic              done
);
   seq_ph_e          ph;
   logic [IDX_W-1:0] idx;
   logic             last_word;

   assign last_word = (idx == IDX_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_ENTER;
         idx <= '0;
      end else if (start) begin
         ph  <= PH_ENTER;
         idx <= '0;
      end else if (expired) begin
         unique case (ph)
            PH_ENTER: ph <= PH_ADDR;
            PH_ADDR:  ph <= PH_STRB;
            PH_STRB:  ph <= PH_LOW;
            PH_LOW: begin
               if (last_word) begin
                  ph <= PH_STBY;
               end else begin
                  idx <= idx + 1'b1;
                  ph  <= PH_ADDR;
               end
            end
            default:  ph <= PH_STBY;
         endcase
      end
   end

   assign reload  = start || (expired && ph != PH_STBY);
   assign cap_en  = (ph == PH_STRB) && expired && !start;
   assign cap_idx = idx;
   assign done    = (ph == PH_STBY);

   always_comb begin
      ctrl              = '0;
      ctrl[PGENB_BIT]   = 1'b1;
      ctrl[CSB_BIT]     = (ph == PH_STBY);
      ctrl[LOAD_BIT]    = (ph != PH_STBY);
      ctrl[STROBE_BIT]  = (ph == PH_STRB);
      if (ph == PH_ADDR || ph == PH_STRB || ph == PH_LOW)
         ctrl[ADDR_LSB +: ADDR_W] = ADDR_W'(idx);
   end

   // R4
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ctrl[ADDR_LSB +: ADDR_W]) < WORDS);

   // R2
   strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[STROBE_BIT] |-> (ctrl[LOAD_BIT] && !ctrl[CSB_BIT] && ctrl[PGENB_BIT]));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && ph == PH_LOW && expired && !last_word) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/efuse_shadow_store.sv
`timescale 1ns/1ps
module efuse_shadow_store #(
   parameter int WORDS      = 32,
   parameter int WORD_W     = 32,
   parameter int VER_WORD   = 6,
   parameter int VER_W      = 4,
   parameter int LEAK_WORD  = 23,
   parameter bit DECODE_REG = 1'b0,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [WORD_W-1:0] cap_data,
   input  logic              done,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data,
   output logic [VER_W-1:0]  chip_ver,
   output logic [WORD_W-1:0] cpu_leak
);
   logic [WORD_W-1:0] shadow [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++)
            shadow[i] <= '0;
      end else if (cap_en) begin
         shadow[cap_idx] <= cap_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else
         rd_data <= done ? shadow[rd_idx] : '0;
   end

   generate
      if (DECODE_REG) begin : g_dec_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chip_ver <= '0;
               cpu_leak <= '0;
            end else begin
               chip_ver <= done ? shadow[VER_WORD][VER_W-1:0] : '0;
               cpu_leak <= done ? shadow[LEAK_WORD] : '0;
            end
         end
         // R6
         dec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !done |=> (chip_ver == '0 && cpu_leak == '0));
      end else begin : g_dec_comb
         assign chip_ver = done ? shadow[VER_WORD][VER_W-1:0] : '0;
         assign cpu_leak = done ? shadow[LEAK_WORD] : '0;
         // R6
         dec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !done |-> (chip_ver == '0 && cpu_leak == '0));
      end
   endgenerate

   // R6
   rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (rd_data == '0));

   // R3
   cap_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> !done);
endmodule

// File: rtl/efuse_shadow_loader.sv
`timescale 1ns/1ps
module efuse_shadow_loader import efuse_shadow_pkg::*; #(
   parameter int SETTLE_CYC = 200,
   parameter int WORDS      = 32,
   parameter int WORD_W     = 32,
   parameter int ADDR_W     = 10,
   parameter int VER_WORD   = 6,
   parameter int VER_W      = 4,
   parameter int LEAK_WORD  = 23,
   parameter bit DECODE_REG = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   output logic [ADDR_LSB+ADDR_W-1:0]   fuse_ctrl,
   input  logic [WORD_W-1:0]            fuse_dout,
   input  logic [$clog2(WORDS)-1:0]     rd_idx,
   output logic [WORD_W-1:0]            rd_data,
   output logic                         done,
   output logic [VER_W-1:0]             chip_ver,
   output logic [WORD_W-1:0]            cpu_leak
);
   localparam int IDX_W  = $clog2(WORDS);
   localparam int CTRL_W = ADDR_LSB + ADDR_W;
   localparam logic [CTRL_W-1:0] STBY_WORD  = CTRL_W'((1 << PGENB_BIT) | (1 << CSB_BIT));
   localparam logic [CTRL_W-1:0] ENTRY_WORD = CTRL_W'((1 << PGENB_BIT) | (1 << LOAD_BIT));

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (WORDS < 2 || WORDS > (1 << ADDR_W)) begin : g_bad_words
         $error("WORDS must fit the address field");
      end
      if (VER_WORD >= WORDS || LEAK_WORD >= WORDS) begin : g_bad_field
         $error("decoded word index out of range");
      end
      if (VER_W < 1 || VER_W > WORD_W) begin : g_bad_ver
         $error("VER_W must fit in a word");
      end
   endgenerate

   logic             expired;
   logic             reload;
   logic             cap_en;
   logic [IDX_W-1:0] cap_idx;

   efuse_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) timer_i (
      .clk(clk), .rst_n(rst_n), .reload(reload), .expired(expired)
   );

   efuse_load_fsm #(.WORDS(WORDS), .ADDR_W(ADDR_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .start(start), .expired(expired),
      .reload(reload), .cap_en(cap_en), .cap_idx(cap_idx),
      .ctrl(fuse_ctrl), .done(done)
   );

   efuse_shadow_store #(
      .WORDS(WORDS), .WORD_W(WORD_W), .VER_WORD(VER_WORD), .VER_W(VER_W),
      .LEAK_WORD(LEAK_WORD), .DECODE_REG(DECODE_REG)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
      .cap_data(fuse_dout), .done(done), .rd_idx(rd_idx), .rd_data(rd_data),
      .chip_ver(chip_ver), .cpu_leak(cpu_leak)
   );

   // R5
   standby_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fuse_ctrl == STBY_WORD));

   // R3
   cap_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> fuse_ctrl[STROBE_BIT]);

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && fuse_ctrl == ENTRY_WORD));
endmodule

// File: tb/efuse_shadow_loader_tb_top.sv
`timescale 1ns/1ps
module efuse_shadow_loader_tb_top;
   localparam int S  = 3;
   localparam int NW = 32;
   localparam int L  = S + NW * 3 * S;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] fuse_ctrl;
   logic [31:0] fuse_dout;
   logic [4:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        done;
   logic [3:0]  chip_ver;
   logic [31:0] cpu_leak;

   logic [31:0] mem [NW];
   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   efuse_shadow_loader #(.SETTLE_CYC(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .fuse_ctrl(fuse_ctrl),
      .fuse_dout(fuse_dout), .rd_idx(rd_idx), .rd_data(rd_data),
      .done(done), .chip_ver(chip_ver), .cpu_leak(cpu_leak)
   );

   function automatic logic [31:0] model_word(input logic [9:0] a);
      if (a < 10'(NW)) return mem[a[4:0]];
      return 32'hBAD0_0000 ^ {22'd0, a};
   endfunction

   // behavioural array: data only while strobed in read mode
   assign fuse_dout = (fuse_ctrl[1] && !fuse_ctrl[0] && fuse_ctrl[2])
                      ? model_word(fuse_ctrl[15:6]) : 32'h0;

   function automatic logic [15:0] exp_ctrl(input int k);
      int kk, w, p;
      if (k < S) return 16'h000C;
      kk = k - S;
      w  = kk / (3 * S);
      p  = (kk % (3 * S)) / S;
      if (w >= NW) return 16'h0009;
      return 16'((w << 6) | 12 | ((p == 1) ? 2 : 0));
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic fill_random();
      for (int i = 0; i < NW; i++) mem[i] = $urandom;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // called on the negedge that is sample k=0
   task automatic run_timeline(input int kmax);
      int e_ctrl = 0, e_done = 0, e_zero = 0;
      logic [31:0] a_ctrl = 0, x_ctrl = 0, a_done = 0, x_done = 0, a_zero = 0;
      for (int k = 0; k <= kmax; k++) begin
         if (k > 0) @(negedge clk);
         if (fuse_ctrl != exp_ctrl(k)) begin
            if (e_ctrl == 0) begin a_ctrl = {16'd0, fuse_ctrl}; x_ctrl = {16'd0, exp_ctrl(k)}; end
            e_ctrl++;
         end
         if (done != (k >= L)) begin
            if (e_done == 0) begin a_done = {31'd0, done}; x_done = 32'(k >= L); end
            e_done++;
         end
         if (k < L && (chip_ver != 0 || cpu_leak != 0)) begin
            if (e_zero == 0) a_zero = cpu_leak | {28'd0, chip_ver};
            e_zero++;
         end
         if (k >= 1 && k <= L && rd_data != 0) begin
            if (e_zero == 0) a_zero = rd_data;
            e_zero++;
         end
         rd_idx = 5'($urandom_range(0, NW - 1));
      end
      chk(e_ctrl == 0, "R1/R2/R4", "control word sequence", a_ctrl, x_ctrl);
      chk(e_done == 0, "R5", "done timing", a_done, x_done);
      chk(e_zero == 0, "R6", "outputs zero before done", a_zero, 32'h0);
   endtask

   task automatic read_word(input int i, input string req);
      rd_idx = 5'(i);
      @(negedge clk);
      chk(rd_data == mem[i], req, $sformatf("read word %0d", i), rd_data, mem[i]);
   endtask

   task automatic check_fields(input string tag);
      chk(chip_ver == mem[6][3:0], "R8", {tag, " chip_ver"}, {28'd0, chip_ver}, {28'd0, mem[6][3:0]});
      chk(cpu_leak == mem[23], "R8", {tag, " cpu_leak"}, cpu_leak, mem[23]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      fill_random();
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R5", "reset done", {31'd0, done}, 32'h0);
      chk(fuse_ctrl == 16'h000C, "R1", "reset control word", {16'd0, fuse_ctrl}, 32'h000C);
      chk(chip_ver == 0 && cpu_leak == 0, "R6", "reset fields", cpu_leak, 32'h0);
      chk(rd_data == 0, "R6", "reset read data", rd_data, 32'h0);

      // first load after reset
      rst_n = 1'b1;
      run_timeline(L + 4);
      read_word(0, "R3");
      read_word(31, "R4");
      for (int n = 0; n < 40; n++) read_word($urandom_range(0, NW - 1), "R7");
      check_fields("load1");

      // restart in mid-load with new contents
      fill_random();
      pulse_start();
      run_timeline(100);
      fill_random();
      pulse_start();
      run_timeline(L + 4);
      for (int i = 0; i < NW; i++) read_word(i, "R9");
      check_fields("restart");

      // directed patterns for the decoded fields
      for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
      mem[6]  = 32'h1234_56A5;
      mem[23] = 32'h8000_0001;
      pulse_start();
      run_timeline(L + 4);
      check_fields("directed");
      read_word(6, "R7");
      read_word(23, "R7");

      for (int i = 0; i < NW; i++) mem[i] = 32'h0;
      pulse_start();
      run_timeline(L + 4);
      check_fields("zeros");
      read_word(31, "R3");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule